// File: doc/BRIEF.md
# Macroblock Reuse-Counter Bypass Table

This block follows how often each 1 KB region of memory (a macroblock) is referenced and, when a data-cache access misses, decides whether the incoming line should skip the cache. Each table entry belongs to one macroblock. The table is direct-mapped and each entry holds a tag, a valid flag and a saturating reuse counter. Every accepted access looks up its macroblock at the same time as the cache lookup. A matching entry counts up. A missing entry is claimed and given a starting value.

When an access misses in the cache, the block uses the following cycle for a second lookup. That lookup reads the counter of the macroblock that owns the line about to be evicted, and lowers that counter by one. The decision then compares the requester's counter with the lowered victim counter and is presented as a registered pulse. A mode input controls how new entries start. With the mode input low, new entries start at zero, which suits a cache close to the core. With it high, they inherit the victim's counter, which suits a cache in front of a slow bus.

Top module: `macroblock_bypass_table`

## Requirements
- R1: After reset no entry is valid, `decValid` and `decBypass` are 0 and `accReady` is 1.
- R2: An address maps to a macroblock by bits 31:10. The entry index is bits [10+IDX_W-1:10] (bits 18:10 for 512 entries) and the tag is the bits above the index. Bits 9:0 have no effect.
- R3: An accepted access whose macroblock has a valid entry raises that counter by one. The counter stays at its maximum (255 for 8 bits) once saturated.
- R4: An accepted access with no matching entry writes the tag, sets the entry valid and sets the counter to 0. This overwrites any other macroblock held at that index.
- R5: In the cycle after an accepted miss, the victim macroblock's counter, if present, is lowered by one. It stays at 0 once it reaches 0.
- R6: The requester value ctr1 is the counter read before its own increment. The victim value ctr2 is the victim counter after it is lowered. Bypass is 1 exactly when ctr1 − 1 < ctr2, taken as signed integers.
- R7: A requester with no entry uses ctr1 = all ones. A victim with no entry uses a read value of 0.
- R8: When `initFromVictim` is 1 at the time of an allocating miss, the new entry's counter is overwritten in the second-lookup cycle with the victim's counter as read before lowering, or 0 if the victim is absent.
- R9: `decValid` is a one-cycle pulse that appears two clock edges after the edge that accepts a missing access. Hits produce no pulse.
- R10: `accReady` is 0 during the second-lookup cycle. An access presented then is ignored and must be held.
- R11: `decBypass` is 0 whenever `decValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access strobe |
| accAddr | input | 32 | Byte address of the access |
| accHit | input | 1 | Cache hit indication for this access |
| victimAddr | input | 32 | Address of the line that would be evicted |
| initFromVictim | input | 1 | 1: new entries inherit the victim count; 0: start at 0 |
| accReady | output | 1 | Access accepted this cycle when high |
| decValid | output | 1 | Decision pulse |
| decBypass | output | 1 | 1 = bypass the cache, 0 = allocate normally |

## Verification
The hardest states to reach from the ports are a counter pinned at its maximum, and a victim lookup that meets an entry the same miss has just claimed or overwritten at a shared index. The stimulus first drives a long run of hits to a single macroblock to saturate it, then pits misses against it. After that it uses a handful of tags on four indices, plus the top index and the all-ones tag, so that overwrites, absent victims and coinciding indices happen often in both init modes. Accesses are also offered during stall cycles to confirm they are ignored.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef struct packed {
    logic accept;   // access taken this cycle
    logic capMiss;  // accepted access missed: capture for second lookup
    logic lookup2;  // second lookup cycle
  } mbt_strobe_t;
endpackage

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accValid,
  input  logic        accHit,
  output logic        accReady,
  output logic        decValid,
  output mbt_strobe_t strobe
);
  logic s1Valid;

  assign accReady       = !s1Valid;
  assign strobe.accept  = accValid && !s1Valid;
  assign strobe.capMiss = accValid && !s1Valid && !accHit;
  assign strobe.lookup2 = s1Valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      decValid <= 1'b0;
    end else begin
      s1Valid  <= strobe.capMiss;
      decValid <= s1Valid;
    end
  end

  a_r10_stall_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accReady && !accHit) |=> !accReady);
  a_r9_decision_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accReady && !accHit) |=> ##1 decValid);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    decValid |=> !decValid);
endmodule

// File: rtl/mbt_datapath.sv
module mbt_datapath
  import mbt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MB_SHIFT = 10,
  parameter int ENTRIES  = 512,
  parameter int CTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mbt_strobe_t       strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              initFromVictim,
  input  logic              decValid,
  output logic              decBypass
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - MB_SHIFT - IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [TAG_W-1:0] tagTbl [ENTRIES];
  logic [CTR_W-1:0] ctrTbl [ENTRIES];
  logic             vldTbl [ENTRIES];

  // first lookup
  logic [IDX_W-1:0] accIdx;
  logic [TAG_W-1:0] accTag;
  logic             accFound;
  logic [CTR_W-1:0] accCtr;
  assign accIdx   = accAddr[MB_SHIFT +: IDX_W];
  assign accTag   = accAddr[ADDR_W-1 -: TAG_W];
  assign accFound = vldTbl[accIdx] && (tagTbl[accIdx] == accTag);
  assign accCtr   = ctrTbl[accIdx];

  // captured state for the second lookup
  logic [CTR_W-1:0] pendCtr1;
  logic [IDX_W-1:0] pendAllocIdx;
  logic             pendInitL2;
  logic [IDX_W-1:0] vicIdx;
  logic [TAG_W-1:0] vicTag;

  logic             vicFound;
  logic [CTR_W-1:0] vicRaw;
  logic [CTR_W-1:0] vicDec;
  logic             bypassNext;
  assign vicFound   = vldTbl[vicIdx] && (tagTbl[vicIdx] == vicTag);
  assign vicRaw     = vicFound ? ctrTbl[vicIdx] : '0;
  assign vicDec     = (vicRaw == '0) ? '0 : vicRaw - 1'b1;
  // ctr1 - 1 < ctr2  <=>  ctr1 <= ctr2 over the integers
  assign bypassNext = (pendCtr1 <= vicDec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCtr1     <= '0;
      pendAllocIdx <= '0;
      pendInitL2   <= 1'b0;
      vicIdx       <= '0;
      vicTag       <= '0;
      decBypass    <= 1'b0;
    end else begin
      decBypass <= strobe.lookup2 && bypassNext;
      if (strobe.capMiss) begin
        pendCtr1     <= accFound ? accCtr : CTR_MAX;
        pendAllocIdx <= accIdx;
        pendInitL2   <= initFromVictim && !accFound;
        vicIdx       <= victimAddr[MB_SHIFT +: IDX_W];
        vicTag       <= victimAddr[ADDR_W-1 -: TAG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vldTbl[i] <= 1'b0;
        tagTbl[i] <= '0;
        ctrTbl[i] <= '0;
      end
    end else if (strobe.lookup2) begin
      if (vicFound) ctrTbl[vicIdx] <= vicDec;
      if (pendInitL2) ctrTbl[pendAllocIdx] <= vicRaw;
    end else if (strobe.accept) begin
      if (accFound) begin
        if (accCtr != CTR_MAX) ctrTbl[accIdx] <= accCtr + 1'b1;
      end else begin
        vldTbl[accIdx] <= 1'b1;
        tagTbl[accIdx] <= accTag;
        ctrTbl[accIdx] <= '0;
      end
    end
  end

  a_r11_bypass_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !decValid |-> !decBypass);
  a_r3_counter_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.accept && !strobe.capMiss && accFound && accCtr == CTR_MAX)
      |=> ctrTbl[$past(accIdx)] == CTR_MAX);
  a_r7_absent_requester_allocates: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lookup2 && pendCtr1 == CTR_MAX) |=> !decBypass);
  a_r4_alloc_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.accept && !accFound) |=> vldTbl[$past(accIdx)]);
endmodule

// File: rtl/macroblock_bypass_table.sv
module macroblock_bypass_table
  import mbt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MB_SHIFT = 10,
  parameter int ENTRIES  = 512,
  parameter int CTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accHit,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              initFromVictim,
  output logic              accReady,
  output logic              decValid,
  output logic              decBypass
);
  mbt_strobe_t strobe;

  mbt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accHit(accHit),
    .accReady(accReady), .decValid(decValid), .strobe(strobe)
  );

  mbt_datapath #(
    .ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT), .ENTRIES(ENTRIES), .CTR_W(CTR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .accAddr(accAddr),
    .victimAddr(victimAddr), .initFromVictim(initFromVictim),
    .decValid(decValid), .decBypass(decBypass)
  );
endmodule

// File: tb/macroblock_bypass_table_test.sv
module macroblock_bypass_table_test;
  localparam int ENT  = 512;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accValid = 1'b0, accHit = 1'b0, initFromVictim = 1'b0;
  logic [31:0] accAddr = '0, victimAddr = '0;
  logic accReady, decValid, decBypass;

  always #5 clk = ~clk;

  macroblock_bypass_table uut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accAddr(accAddr),
    .accHit(accHit), .victimAddr(victimAddr), .initFromVictim(initFromVictim),
    .accReady(accReady), .decValid(decValid), .decBypass(decBypass)
  );

  int compared = 0, mismatched = 0;

  // reference model state
  bit mVld[ENT];
  int mTag[ENT];
  int mCtr[ENT];
  bit pend;
  int pCtr1, pVicIdx, pVicTag, pAllocIdx;
  bit pInit;
  bit eReady, eDecValid, eDecBypass;

  function automatic int idxOf(logic [31:0] a); return int'(a[18:10]); endfunction
  function automatic int tagOf(logic [31:0] a); return int'(a[31:19]); endfunction
  function automatic logic [31:0] mk(int tag, int idx, int low);
    return {tag[12:0], idx[8:0], low[9:0]};
  endfunction

  task automatic modelReset();
    for (int i = 0; i < ENT; i++) begin mVld[i] = 0; mTag[i] = 0; mCtr[i] = 0; end
    pend = 0; eReady = 1; eDecValid = 0; eDecBypass = 0;
  endtask

  // advance the model across one clock edge with the current inputs
  task automatic modelStep();
    if (pend) begin
      int raw, dec, c2;
      bit found;
      found = mVld[pVicIdx] && mTag[pVicIdx] == pVicTag;   // R7 absent victim reads 0
      raw = found ? mCtr[pVicIdx] : 0;
      dec = (raw > 0) ? raw - 1 : 0;                        // R5
      if (found) mCtr[pVicIdx] = dec;
      if (pInit) mCtr[pAllocIdx] = raw;                     // R8
      c2 = dec;
      eDecValid = 1; eDecBypass = ((pCtr1 - 1) < c2);       // R6
      pend = 0; eReady = 1;
    end else begin
      eDecValid = 0; eDecBypass = 0;                        // R11
      if (accValid) begin
        int i, t; bit found;
        i = idxOf(accAddr); t = tagOf(accAddr);             // R2
        found = mVld[i] && mTag[i] == t;
        if (!accHit) begin
          pend = 1; eReady = 0;                             // R10
          pCtr1 = found ? mCtr[i] : CMAX;                   // R7
          pVicIdx = idxOf(victimAddr); pVicTag = tagOf(victimAddr);
          pAllocIdx = i; pInit = initFromVictim && !found;
        end
        if (found) begin if (mCtr[i] < CMAX) mCtr[i]++; end // R3
        else begin mVld[i] = 1; mTag[i] = t; mCtr[i] = 0; end // R4
      end
    end
  endtask

  task automatic chk(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R10 accReady", accReady, eReady);
    chk("R9 decValid", decValid, eDecValid);
    chk("R6 decBypass", decBypass, eDecBypass);
  endtask

  // one cycle: compare outputs at the negedge, drive inputs, advance the model
  task automatic cyc(bit v, logic [31:0] a, bit h, logic [31:0] va, bit m);
    @(negedge clk);
    compareAll();
    accValid = v; accAddr = a; accHit = h; victimAddr = va; initFromVictim = m;
    modelStep();
  endtask

  task automatic randPhase(int n, bit mode);
    for (int k = 0; k < n; k++) begin
      int t, i, t2, i2;
      t = $urandom_range(0, 3); if (t == 3) t = 8191;
      i = $urandom_range(0, 4); if (i == 4) i = 511;
      t2 = $urandom_range(0, 3); if (t2 == 3) t2 = 8191;
      i2 = ($urandom_range(0, 2) == 0) ? i : $urandom_range(0, 3);
      cyc($urandom_range(0, 9) < 8, mk(t, i, $urandom_range(0, 1023)),
          $urandom_range(0, 9) < 4, mk(t2, i2, $urandom_range(0, 1023)), mode);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1 accReady", accReady, 1'b1);
    chk("R1 decValid", decValid, 1'b0);
    chk("R1 decBypass", decBypass, 1'b0);
    // R4/R7: miss to empty table with absent victim -> requester all ones, no bypass
    cyc(1, mk(1, 2, 5), 0, mk(2, 3, 0), 0);
    cyc(1, mk(3, 3, 0), 1, '0, 0);            // R10: offered during stall, ignored
    cyc(0, '0, 0, '0, 0);
    cyc(0, '0, 0, '0, 0);
    // R3: saturate one macroblock, low bits varying (R2)
    for (int k = 0; k < 300; k++) cyc(1, mk(5, 7, k), 1, '0, 0);
    // R5/R6: misses against the saturated victim, requester freshly allocated at 0
    for (int k = 0; k < 6; k++) begin
      cyc(1, mk(6, 8, 0), 0, mk(5, 7, 9), 0);
      cyc(0, '0, 0, '0, 0);
    end
    // R8: second-level init mode
    for (int k = 0; k < 4; k++) begin
      cyc(1, mk(9 + k, 20, 0), 0, mk(5, 7, 0), 1);
      cyc(0, '0, 0, '0, 0);
    end
    // R2/R4/R5/R9: random mixes in both modes
    randPhase(3000, 0);
    randPhase(3000, 1);
    randPhase(2000, 0);
    cyc(0, '0, 0, '0, 0);
    cyc(0, '0, 0, '0, 0);
    cyc(0, '0, 0, '0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule